// File: doc/BRIEF.md
# DS3 Performance Monitor Counter Bank

This block keeps four error counters for a DS3 demultiplexer. A framer upstream reports per-frame events: how many F-bit and M-bit errors it found, whether the P bits disagreed with the previous frame's parity, the three C-bit parity error flags, and the three far-end block error bits. Each counter has a running accumulator and a hold register. A processor reads only the hold registers.

A one-cycle snapshot pulse, usually produced once per second, copies every running count into its hold register and restarts the running count. If snapshots stop arriving, a mode input chooses what the accumulators do when they reach their limit. With saturation, they stay at all ones. With wrapping, they continue modulo their width. The C-bit and far-end counters advance only while C-bit parity mode is enabled.

Top module: `ds3_pm_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all four running counts and all four held counts become zero.
- R2: On a cycle with `pm_snap` high, every held count takes the running count from before that edge. Every running count restarts from zero plus that cycle's increment.
- R3: Held counts change only on cycles with `pm_snap` high (or reset).
- R4: On a `frame_stb` cycle, the 12-bit framing counter adds `fm_errs`, a count from 0 to 31 of F-bit and M-bit errors.
- R5: On a `frame_stb` cycle with `p_bad` high, the 14-bit parity counter adds exactly one. It never adds more than one per cycle.
- R6: On a `frame_stb` cycle, the 14-bit C-bit counter adds one when at least two bits of `cp_err` are 1 (1 = error) and `cbit_mode` is high. With `cbit_mode` low it does not change.
- R7: On a `frame_stb` cycle, the 14-bit far-end counter adds one when at least one bit of `febe_bits` is 0 (0 = error) and `cbit_mode` is high. With `cbit_mode` low it does not change.
- R8: With `sat_mode` high, a counter that would pass its maximum stops at all ones, even when a multi-count add would overshoot.
- R9: With `sat_mode` low, a counter that passes its maximum wraps modulo 2^width.
- R10: When `pm_snap` and a frame event fall in the same cycle, the event is not in the held value. The running count restarts at the event's increment.
- R11: With `frame_stb` low, `fm_errs`, `p_bad`, `cp_err` and `febe_bits` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | Qualifies the per-frame event inputs |
| fm_errs | input | 5 | Number of F/M-bit errors in this frame |
| p_bad | input | 1 | P-bit parity disagreement in this frame |
| cp_err | input | 3 | C-bit parity error flags, 1 = error |
| febe_bits | input | 3 | Far-end block error bits, 0 = error |
| cbit_mode | input | 1 | Enables the C-bit and far-end counters |
| sat_mode | input | 1 | 1 = saturate at maximum, 0 = wrap |
| pm_snap | input | 1 | Snapshot pulse: latch running counts and restart them |
| fm_hold | output | 12 | Held F/M-bit error count |
| p_hold | output | 14 | Held P-bit error count |
| cp_hold | output | 14 | Held C-bit parity error frame count |
| febe_hold | output | 14 | Held far-end error frame count |

## Verification
The assertions check on every cycle that held values move only on a snapshot and then equal the previous running value. They also check that a snapshot without an event clears the accumulators, that idle or non-C-bit cycles leave the relevant accumulators still, that the parity counter steps by at most one, and that a saturated counter stays pinned. The bench scenarios show the cases that need a whole history. These are the 2-of-3 and any-zero counting rules, multi-error adds, the exact wrap residue and saturation clamp after many frames, and the split of a simultaneous event and snapshot between two intervals.

// File: rtl/ds3_pm_pkg.sv
package ds3_pm_pkg;
  localparam int FM_CNT_W  = 12;
  localparam int PAR_CNT_W = 14;
  localparam int FM_INC_W  = 5;
  localparam int NUM_FLAG  = 3;  // parity, C-bit, far-end single-step counters
  localparam int IDX_P     = 0;
  localparam int IDX_CP    = 1;
  localparam int IDX_FE    = 2;

  function automatic logic two_of_three(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/pm_event_decode.sv
module pm_event_decode #(
  parameter int FM_IW = ds3_pm_pkg::FM_INC_W,
  parameter int NFLAG = ds3_pm_pkg::NUM_FLAG
) (
  input  logic             frame_stb,
  input  logic [FM_IW-1:0] fm_errs,
  input  logic             p_bad,
  input  logic [2:0]       cp_err,
  input  logic [2:0]       febe_bits,
  input  logic             cbit_mode,
  output logic [FM_IW-1:0] fm_inc,
  output logic [NFLAG-1:0] flag_inc
);
  import ds3_pm_pkg::*;

  always_comb begin
    fm_inc   = frame_stb ? fm_errs : '0;
    flag_inc = '0;
    flag_inc[IDX_P]  = frame_stb & p_bad;
    flag_inc[IDX_CP] = frame_stb & cbit_mode & two_of_three(cp_err);
    flag_inc[IDX_FE] = frame_stb & cbit_mode & ~(&febe_bits);
  end
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W  = 14,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snap,
  input  logic          sat,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  run_q,
  output logic [W-1:0]  hold_q
);
  localparam int SW = W + 1;

  logic [W-1:0]  base;
  logic [SW-1:0] sum;
  logic [W-1:0]  next_run;

  always_comb begin
    base = snap ? '0 : run_q;
    sum  = {1'b0, base} + SW'(inc);
    if (sum[W] && sat) next_run = '1;
    else               next_run = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      run_q <= next_run;
      if (snap) hold_q <= run_q;
    end
  end
endmodule

// File: rtl/ds3_pm_bank.sv
module ds3_pm_bank #(
  parameter int FM_W  = ds3_pm_pkg::FM_CNT_W,
  parameter int PAR_W = ds3_pm_pkg::PAR_CNT_W,
  parameter int FM_IW = ds3_pm_pkg::FM_INC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic [FM_IW-1:0] fm_errs,
  input  logic             p_bad,
  input  logic [2:0]       cp_err,
  input  logic [2:0]       febe_bits,
  input  logic             cbit_mode,
  input  logic             sat_mode,
  input  logic             pm_snap,
  output logic [FM_W-1:0]  fm_hold,
  output logic [PAR_W-1:0] p_hold,
  output logic [PAR_W-1:0] cp_hold,
  output logic [PAR_W-1:0] febe_hold
);
  import ds3_pm_pkg::*;
  localparam int NF = NUM_FLAG;

  logic [FM_IW-1:0] fm_inc;
  logic [NF-1:0]    flag_inc;
  logic [FM_W-1:0]  fm_run;
  logic [PAR_W-1:0] run_arr  [NF];
  logic [PAR_W-1:0] hold_arr [NF];
  logic [PAR_W-1:0] p_run, cp_run, fe_run;

  pm_event_decode #(.FM_IW(FM_IW), .NFLAG(NF)) u_dec (
    .frame_stb (frame_stb),
    .fm_errs   (fm_errs),
    .p_bad     (p_bad),
    .cp_err    (cp_err),
    .febe_bits (febe_bits),
    .cbit_mode (cbit_mode),
    .fm_inc    (fm_inc),
    .flag_inc  (flag_inc)
  );

  pm_counter #(.W(FM_W), .IW(FM_IW)) u_fm (
    .clk (clk), .rst (rst), .snap (pm_snap), .sat (sat_mode),
    .inc (fm_inc), .run_q (fm_run), .hold_q (fm_hold)
  );

  for (genvar g = 0; g < NF; g++) begin : g_flag
    pm_counter #(.W(PAR_W), .IW(1)) u_cnt (
      .clk (clk), .rst (rst), .snap (pm_snap), .sat (sat_mode),
      .inc (flag_inc[g]), .run_q (run_arr[g]), .hold_q (hold_arr[g])
    );
  end

  assign p_run     = run_arr[IDX_P];
  assign cp_run    = run_arr[IDX_CP];
  assign fe_run    = run_arr[IDX_FE];
  assign p_hold    = hold_arr[IDX_P];
  assign cp_hold   = hold_arr[IDX_CP];
  assign febe_hold = hold_arr[IDX_FE];
endmodule

// File: rtl/ds3_pm_bank_chk.sv
module ds3_pm_bank_chk #(
  parameter int FM_W  = 12,
  parameter int PAR_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_stb,
  input logic             cbit_mode,
  input logic             sat_mode,
  input logic             pm_snap,
  input logic [FM_W-1:0]  fm_run,
  input logic [PAR_W-1:0] p_run,
  input logic [PAR_W-1:0] cp_run,
  input logic [PAR_W-1:0] fe_run,
  input logic [FM_W-1:0]  fm_hold,
  input logic [PAR_W-1:0] p_hold,
  input logic [PAR_W-1:0] cp_hold,
  input logic [PAR_W-1:0] febe_hold
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=>
    (fm_run == '0 && p_run == '0 && cp_run == '0 && fe_run == '0 &&
     fm_hold == '0 && p_hold == '0 && cp_hold == '0 && febe_hold == '0));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !pm_snap |=> ($stable(fm_hold) && $stable(p_hold) && $stable(cp_hold) && $stable(febe_hold)));

  // R2
  hold_capture_chk: assert property (@(posedge clk) disable iff (rst)
    pm_snap |=> (fm_hold == $past(fm_run) && p_hold == $past(p_run) &&
                 cp_hold == $past(cp_run) && febe_hold == $past(fe_run)));

  // R2
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_snap && !frame_stb) |=> (fm_run == '0 && p_run == '0 && cp_run == '0 && fe_run == '0));

  // R5
  p_single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !pm_snap |=> (PAR_W'(p_run - $past(p_run)) <= PAR_W'(1)));

  // R6 R7
  cbit_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cbit_mode && !pm_snap) |=> ($stable(cp_run) && $stable(fe_run)));

  // R8
  sat_pinned_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_mode && !pm_snap && fm_run == '1) |=> (fm_run == '1));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_stb && !pm_snap) |=> ($stable(fm_run) && $stable(p_run) && $stable(cp_run) && $stable(fe_run)));
endmodule

bind ds3_pm_bank ds3_pm_bank_chk #(.FM_W(FM_W), .PAR_W(PAR_W)) u_chk (.*);

// File: tb/ds3_pm_bank_test.sv
`timescale 1ns/1ps
module ds3_pm_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic [4:0] fm_errs = '0;
  logic       p_bad = 1'b0;
  logic [2:0] cp_err = '0;
  logic [2:0] febe_bits = 3'b111;
  logic       cbit_mode = 1'b1;
  logic       sat_mode = 1'b0;
  logic       pm_snap = 1'b0;
  logic [11:0] fm_hold;
  logic [13:0] p_hold, cp_hold, febe_hold;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ds3_pm_bank uut (.*);

  // vector: stb, fm[5], pb, cp[3], fb[3], cb, snap, exp fm[12], p[14], cp[14], fe[14]
  localparam int VW = 69;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 5'd3,  1'b1, 3'b011, 3'b111, 1'b1, 1'b0, 12'd0,  14'd0, 14'd0, 14'd0},  // R4 R5 R6
    {1'b1, 5'd0,  1'b0, 3'b100, 3'b110, 1'b1, 1'b0, 12'd0,  14'd0, 14'd0, 14'd0},  // R6 R7
    {1'b1, 5'd31, 1'b1, 3'b111, 3'b000, 1'b1, 1'b0, 12'd0,  14'd0, 14'd0, 14'd0},  // R4
    {1'b0, 5'd7,  1'b1, 3'b111, 3'b000, 1'b1, 1'b0, 12'd0,  14'd0, 14'd0, 14'd0},  // R11
    {1'b0, 5'd0,  1'b0, 3'b000, 3'b111, 1'b1, 1'b1, 12'd34, 14'd2, 14'd2, 14'd2},  // R2
    {1'b1, 5'd5,  1'b1, 3'b110, 3'b011, 1'b0, 1'b0, 12'd34, 14'd2, 14'd2, 14'd2},  // R3 R6 R7
    {1'b1, 5'd1,  1'b0, 3'b101, 3'b101, 1'b1, 1'b1, 12'd5,  14'd1, 14'd0, 14'd0},  // R10
    {1'b0, 5'd0,  1'b0, 3'b000, 3'b111, 1'b1, 1'b1, 12'd1,  14'd0, 14'd1, 14'd1},  // R10
    {1'b1, 5'd2,  1'b1, 3'b000, 3'b111, 1'b1, 1'b0, 12'd1,  14'd0, 14'd1, 14'd1},  // R3
    {1'b0, 5'd0,  1'b0, 3'b000, 3'b111, 1'b1, 1'b1, 12'd2,  14'd1, 14'd0, 14'd0}   // R2
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_all(input string req, input int f, input int p, input int c, input int e);
    n_chk++;
    if (fm_hold != 12'(f) || p_hold != 14'(p) || cp_hold != 14'(c) || febe_hold != 14'(e)) begin
      n_bad++;
      $display("FAIL %s: got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d", req,
               fm_hold, p_hold, cp_hold, febe_hold, f, p, c, e);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic stb, input logic [4:0] fm, input logic pb,
                      input logic [2:0] cp, input logic [2:0] fb,
                      input logic cb, input logic snap);
    frame_stb = stb; fm_errs = fm; p_bad = pb; cp_err = cp;
    febe_bits = fb; cbit_mode = cb; pm_snap = snap;
    @(posedge clk);
    @(negedge clk);
    frame_stb = 1'b0; pm_snap = 1'b0;
  endtask

  task automatic snap_only();
    step(1'b0, 5'd0, 1'b0, 3'b000, 3'b111, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_all("R1 reset", 0, 0, 0, 0);

    sat_mode = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[68], v[67:63], v[62], v[61:59], v[58:56], v[55], v[54]);
      check_all($sformatf("R2-R11 vector %0d", i),
                int'(v[53:42]), int'(v[41:28]), int'(v[27:14]), int'(v[13:0]));
    end

    // R8 saturation with multi-count adds: 132*31 = 4092, next add clamps at 4095
    sat_mode = 1'b1;
    for (int i = 0; i < 133; i++) step(1'b1, 5'd31, 1'b0, 3'b000, 3'b111, 1'b1, 1'b0);
    snap_only();
    check("R8 fm saturate", int'(fm_hold), 4095);

    // R9 wrap: 133*31 = 4123 -> 27
    sat_mode = 1'b0;
    for (int i = 0; i < 133; i++) step(1'b1, 5'd31, 1'b0, 3'b000, 3'b111, 1'b1, 1'b0);
    snap_only();
    check("R9 fm wrap", int'(fm_hold), 27);

    // R9 parity counter wraps after 16385 frames -> 1
    for (int i = 0; i < 16385; i++) step(1'b1, 5'd0, 1'b1, 3'b000, 3'b111, 1'b1, 1'b0);
    snap_only();
    check("R9 p wrap", int'(p_hold), 1);

    // R8 parity counter saturates at 16383; R5 one per frame
    sat_mode = 1'b1;
    for (int i = 0; i < 16385; i++) step(1'b1, 5'd0, 1'b1, 3'b000, 3'b111, 1'b1, 1'b0);
    snap_only();
    check("R8 p saturate", int'(p_hold), 16383);

    // R6 R7 C-bit disabled leaves counters untouched
    sat_mode = 1'b0;
    step(1'b1, 5'd0, 1'b0, 3'b111, 3'b000, 1'b0, 1'b0);
    step(1'b1, 5'd0, 1'b0, 3'b011, 3'b001, 1'b0, 1'b0);
    snap_only();
    check("R6 cbit off", int'(cp_hold), 0);
    check("R7 cbit off", int'(febe_hold), 0);

    // R1 mid-run reset clears running counts
    step(1'b1, 5'd9, 1'b1, 3'b111, 3'b000, 1'b1, 1'b0);
    snap_only();
    check_all("R2 pre-reset capture", 9, 1, 1, 1);
    step(1'b1, 5'd4, 1'b1, 3'b111, 3'b000, 1'b1, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 mid-run reset", 0, 0, 0, 0);
    snap_only();
    check_all("R1 running cleared", 0, 0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule